// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Changeover

This block produces a system clock from one of two slow clock sources, a crystal-derived clock and an external frequency input. A select input chooses between them and may change at any moment while the system runs. The block also produces a peripheral clock at half the output frequency. A fast reference clock oversamples both sources, so the whole design is ordinary synchronous logic and the output clock comes straight from a flip-flop.

A request to change source is recognised only while the output clock and the peripheral clock are both high. On the second peripheral-clock falling edge after that, the output is parked low. It then waits for clean edges of the new source before it restarts, so no shortened high or low pulse ever appears. The restart edge depends on the direction of the change. Toward the crystal, the output restarts on the crystal rising edge that comes after two crystal falling edges. Toward the external input, it is released on the external falling edge that comes after two external rising edges, and the first high pulse then starts on the next rising edge. After reset the block begins as if it were switching to the crystal, so even the first pulse is whole.

Top module: `clk_src_switch`

## Requirements
- R1: While reset is asserted, clk_out and pclk_out are 0. After release, clk_out stays 0 until the crystal (select value 0) has shown two falling edges and a rising edge.
- R2: In steady operation, clk_out follows the selected source: sel_ext = 0 picks xtal_clk and sel_ext = 1 picks ext_clk. The high time and the period match that source within one reference cycle, and every clk_out rising edge follows a rising edge of the current source.
- R3: pclk_out changes only in the reference cycle in which clk_out falls. Its high time therefore equals one clk_out period.
- R4: sel_ext is compared with the current source only while clk_out and pclk_out are both 1. A select pulse that begins and ends while pclk_out is 0 causes no changeover.
- R5: Once a change is detected, clk_out is held low from the second following pclk_out falling edge. From the select change to the start of that low stretch there are at most 4 periods of the old source, plus the synchroniser delay.
- R6: When switching to the crystal, clk_out rises again on a crystal rising edge that follows two crystal falling edges. The stretched low lasts between 1.5 and 2.5 crystal periods.
- R7: When switching to the external input, the hold is released on an ext_clk falling edge that follows two ext_clk rising edges. The stretched low, up to the next ext_clk rising edge, lasts between 2 and 3 external periods.
- R8: No high or low pulse of clk_out is shorter than half the period of the faster source, either in steady operation or across any changeover.
- R9: After a changeover, the clk_out period equals the period of the new source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock, at least 4 times either source frequency |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xtal_clk | input | 1 | Crystal-derived source clock (select value 0) |
| ext_clk | input | 1 | External frequency source clock (select value 1) |
| sel_ext | input | 1 | Source select, asynchronous, may change at any time |
| clk_out | output | 1 | Registered system clock output |
| pclk_out | output | 1 | Peripheral clock, half of clk_out, toggles on clk_out falling edges |

## Verification
Every source and select edge takes two reference cycles to pass the synchroniser and one more to reach clk_out. The bench measures pulse widths in whole reference cycles and allows one cycle of tolerance wherever a source edge lands between two reference edges. The start of the freeze may come up to 4 old-source periods after the select change, and the restart may come up to 3 new-source periods after the freeze. Each changeover episode therefore waits a fixed window sized from both periods before any width or latency is checked. The pclk_out and runt-pulse checks run on every reference cycle and are sampled on the falling reference edge, away from the edge where the outputs update.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_ARM    = 2'd1,
    ST_FROZEN = 2'd2
  } sw_state_e;

  localparam logic SRC_XTAL = 1'b0;
  localparam logic SRC_EXT  = 1'b1;
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_n;

      always_comb begin
        chain_n = {chain_q[STAGES-2:0], d[gi]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_n;
      end

      assign q[gi] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cs_ctrl.sv
module cs_ctrl
  import sw_pkg::*;
#(
  parameter int FREEZE_FALLS  = 2,
  parameter int RESTART_EDGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel_lvl,
  input  logic      xt_lvl,
  input  logic      ex_lvl,
  input  logic [1:0] src_rise,
  input  logic [1:0] src_fall,
  output logic      clk_o,
  output logic      pclk_o,
  output sw_state_e state_o,
  output logic      cur_o
);
  localparam int CNT_MAX = (FREEZE_FALLS > RESTART_EDGES) ? FREEZE_FALLS : RESTART_EDGES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] FRZ_LAST = CNT_W'(FREEZE_FALLS - 1);
  localparam logic [CNT_W-1:0] RST_DONE = CNT_W'(RESTART_EDGES);

  sw_state_e        state_q, state_n;
  logic             cur_q, cur_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             clk_q, clk_n;
  logic             pclk_q, pclk_n;
  logic             cur_lvl, fall_evt, pfall;
  logic             cnt_en, clk_en, pclk_en, state_en, cur_en;

  always_comb begin
    cur_lvl  = cur_q ? ex_lvl : xt_lvl;
    fall_evt = clk_q & ~cur_lvl;
    pfall    = fall_evt & pclk_q;
    state_n  = state_q;
    cur_n    = cur_q;
    cnt_n    = cnt_q;
    clk_n    = clk_q;
    pclk_n   = pclk_q;
    unique case (state_q)
      ST_RUN, ST_ARM: begin
        clk_n  = cur_lvl;
        pclk_n = fall_evt ? ~pclk_q : pclk_q;
        if (state_q == ST_RUN) begin
          if (clk_q && pclk_q && (sel_lvl != cur_q)) begin
            state_n = ST_ARM;
            cnt_n   = pfall ? CNT_W'(1) : '0;
          end
        end else if (pfall) begin
          if (cnt_q == FRZ_LAST) begin
            state_n = ST_FROZEN;
            cur_n   = ~cur_q;
            cnt_n   = '0;
            clk_n   = 1'b0;
          end else begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_FROZEN: begin
        clk_n = 1'b0;
        if (cur_q == SRC_XTAL) begin
          if (cnt_q == RST_DONE && src_rise[0]) begin
            state_n = ST_RUN;
            clk_n   = 1'b1;
          end else if (cnt_q != RST_DONE && src_fall[0]) begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end else begin
          if (cnt_q == RST_DONE && src_fall[1]) begin
            state_n = ST_RUN;
            clk_n   = 1'b0;
          end else if (cnt_q != RST_DONE && src_rise[1]) begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end
      end
      default: state_n = ST_FROZEN;
    endcase
    state_en = (state_n != state_q);
    cur_en   = (cur_n != cur_q);
    cnt_en   = (cnt_n != cnt_q);
    clk_en   = (clk_n != clk_q);
    pclk_en  = (pclk_n != pclk_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FROZEN;
      cur_q   <= SRC_XTAL;
      cnt_q   <= '0;
      clk_q   <= 1'b0;
      pclk_q  <= 1'b0;
    end else begin
      if (state_en) state_q <= state_n;
      if (cur_en)   cur_q   <= cur_n;
      if (cnt_en)   cnt_q   <= cnt_n;
      if (clk_en)   clk_q   <= clk_n;
      if (pclk_en)  pclk_q  <= pclk_n;
    end
  end

  assign clk_o   = clk_q;
  assign pclk_o  = pclk_q;
  assign state_o = state_q;
  assign cur_o   = cur_q;
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import sw_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int FREEZE_FALLS  = 2,
  parameter int RESTART_EDGES = 2
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic xtal_clk,
  input  logic ext_clk,
  input  logic sel_ext,
  output logic clk_out,
  output logic pclk_out
);
  logic       rst_meta, rst_sync_n;
  logic [2:0] raw_in, lvl;
  logic [1:0] src_prev, src_rise, src_fall;
  sw_state_e  sw_state;
  logic       cur_src;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign raw_in = {sel_ext, ext_clk, xtal_clk};

  cs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_ref),
    .rst_n (rst_sync_n),
    .d     (raw_in),
    .q     (lvl)
  );

  always_ff @(posedge clk_ref or negedge rst_sync_n) begin
    if (!rst_sync_n) src_prev <= '0;
    else             src_prev <= lvl[1:0];
  end

  assign src_rise = lvl[1:0] & ~src_prev;
  assign src_fall = ~lvl[1:0] & src_prev;

  cs_ctrl #(.FREEZE_FALLS(FREEZE_FALLS), .RESTART_EDGES(RESTART_EDGES)) u_ctrl (
    .clk      (clk_ref),
    .rst_n    (rst_sync_n),
    .sel_lvl  (lvl[2]),
    .xt_lvl   (lvl[0]),
    .ex_lvl   (lvl[1]),
    .src_rise (src_rise),
    .src_fall (src_fall),
    .clk_o    (clk_out),
    .pclk_o   (pclk_out),
    .state_o  (sw_state),
    .cur_o    (cur_src)
  );
endmodule

// File: rtl/cs_switch_chk.sv
module cs_switch_chk
  import sw_pkg::*;
(
  input logic       clk_ref,
  input logic       rst_n,
  input logic       clk_out,
  input logic       pclk_out,
  input sw_state_e  state,
  input logic       cur_src,
  input logic [1:0] src_rise
);
  // R4
  sel_window_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ($past(state) == ST_RUN && state == ST_ARM) |-> ($past(clk_out) && $past(pclk_out)));

  // R5
  frozen_low_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (state == ST_FROZEN) |-> !clk_out);

  // R3
  pclk_on_fall_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (pclk_out != $past(pclk_out)) |-> ($past(clk_out) && !clk_out));

  // R2
  rise_follows_src_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(clk_out) |-> $past(src_rise[cur_src]));

  // R6
  xtal_restart_high_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ($past(state) == ST_FROZEN && state == ST_RUN && cur_src == SRC_XTAL) |-> clk_out);

  // R7
  ext_restart_low_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ($past(state) == ST_FROZEN && state == ST_RUN && cur_src == SRC_EXT) |-> !clk_out);
endmodule

bind clk_src_switch cs_switch_chk u_chk (
  .clk_ref  (clk_ref),
  .rst_n    (rst_sync_n),
  .clk_out  (clk_out),
  .pclk_out (pclk_out),
  .state    (sw_state),
  .cur_src  (cur_src),
  .src_rise (src_rise)
);

// File: tb/clk_src_switch_tb.sv
module clk_src_switch_tb;
  localparam int XH = 10;

  logic clk_ref, rst_n, xtal_clk, ext_clk, sel_ext;
  logic clk_out, pclk_out;
  int   eh;
  int   n_chk, n_fail;
  bit   done;

  int cyc, t_edge, t_pedge, last_hi, last_lo, pclk_hi;
  int long_lo, long_start, runt_err, pclk_err, min_half;
  logic prev_c, prev_p;

  clk_src_switch u_dut (
    .clk_ref(clk_ref), .rst_n(rst_n), .xtal_clk(xtal_clk), .ext_clk(ext_clk),
    .sel_ext(sel_ext), .clk_out(clk_out), .pclk_out(pclk_out)
  );

  initial clk_ref = 1'b0;
  always #5 clk_ref = ~clk_ref;

  initial begin
    xtal_clk = 1'b0;
    forever #(XH * 10) xtal_clk = ~xtal_clk;
  end

  initial begin
    ext_clk = 1'b0;
    eh = 6 + int'($urandom(32'd4242) % 9);
    #3;
    forever #(eh * 10) ext_clk = ~ext_clk;
  end

  function automatic int per(input logic src);
    return src ? 2 * eh : 2 * XH;
  endfunction

  function automatic int stretch_min(input logic src);
    return src ? 2 * per(src) - 2 : (3 * per(src)) / 2 - 2;
  endfunction

  function automatic int stretch_max(input logic src);
    return src ? 3 * per(src) + 2 : (5 * per(src)) / 2 + 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // pulse-width monitor, sampled away from the active edge
  always @(negedge clk_ref) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (clk_out !== prev_c) begin
        if (prev_c === 1'b1) begin
          last_hi <= cyc - t_edge;
          if (cyc - t_edge < min_half - 1) runt_err <= runt_err + 1;
        end else begin
          last_lo <= cyc - t_edge;
          if (cyc - t_edge < min_half - 1) runt_err <= runt_err + 1;
          if (cyc - t_edge > 2 * eh + 4 && cyc - t_edge > 2 * XH + 4 - XH) begin
            long_lo    <= cyc - t_edge;
            long_start <= t_edge;
          end
        end
        t_edge <= cyc;
      end
      if (pclk_out !== prev_p) begin
        if (!(prev_c === 1'b1 && clk_out === 1'b0)) pclk_err <= pclk_err + 1;
        if (prev_p === 1'b1) pclk_hi <= cyc - t_pedge;
        t_pedge <= cyc;
      end
    end
    prev_c <= clk_out;
    prev_p <= pclk_out;
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    repeat (150000) @(posedge clk_ref);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic cur;
    int   t_sel, wait_c;
    cyc = 0; t_edge = 0; t_pedge = 0; last_hi = 0; last_lo = 0; pclk_hi = 0;
    long_lo = 0; long_start = 0; runt_err = 0; pclk_err = 0;
    prev_c = 1'b0; prev_p = 1'b0;
    sel_ext = 1'b0;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    #1;
    min_half = (eh < XH) ? eh : XH;
    repeat (10) @(negedge clk_ref);
    chk(clk_out === 1'b0, "R1 clk_out in reset", int'(clk_out), 0);
    chk(pclk_out === 1'b0, "R1 pclk_out in reset", int'(pclk_out), 0);
    @(negedge clk_ref);
    rst_n = 1'b1;
    repeat (5) @(negedge clk_ref);
    chk(clk_out === 1'b0, "R1 held low after release", int'(clk_out), 0);
    repeat (200) @(negedge clk_ref);
    chk(last_hi >= XH - 1 && last_hi <= XH + 1, "R2 crystal high time", last_hi, XH);
    chk(last_hi + last_lo >= 2 * XH - 1 && last_hi + last_lo <= 2 * XH + 1,
        "R2 crystal period", last_hi + last_lo, 2 * XH);
    chk(pclk_hi >= 2 * XH - 1 && pclk_hi <= 2 * XH + 1, "R3 pclk high time", pclk_hi, 2 * XH);

    // R4: select pulse that lives inside a pclk-low interval
    @(negedge clk_ref);
    while (!(prev_p === 1'b1 && pclk_out === 1'b0)) @(negedge clk_ref);
    repeat (2) @(negedge clk_ref);
    long_lo = 0;
    sel_ext = 1'b1;
    repeat (5) @(negedge clk_ref);
    sel_ext = 1'b0;
    repeat (150) @(negedge clk_ref);
    chk(long_lo == 0, "R4 short select pulse ignored (stretch)", long_lo, 0);
    chk(last_hi + last_lo >= 2 * XH - 1 && last_hi + last_lo <= 2 * XH + 1,
        "R4 still on crystal", last_hi + last_lo, 2 * XH);

    cur = 1'b0;
    for (int ep = 0; ep < 6; ep++) begin
      wait_c = int'($urandom % 32'(per(cur)));
      repeat (wait_c) @(negedge clk_ref);
      long_lo = 0; long_start = 0;
      t_sel = cyc;
      sel_ext = ~cur;
      repeat (8 * per(cur) + 4 * per(~cur) + 60) @(negedge clk_ref);
      chk(long_lo != 0 && long_start >= t_sel && long_start - t_sel <= 4 * per(cur) + 4,
          "R5 freeze latency", long_start - t_sel, 4 * per(cur));
      if (~cur)
        chk(long_lo >= stretch_min(1'b1) && long_lo <= stretch_max(1'b1),
            "R7 stretch to external", long_lo, stretch_max(1'b1));
      else
        chk(long_lo >= stretch_min(1'b0) && long_lo <= stretch_max(1'b0),
            "R6 stretch to crystal", long_lo, stretch_max(1'b0));
      chk(last_hi + last_lo >= per(~cur) - 1 && last_hi + last_lo <= per(~cur) + 1,
          "R9 new period", last_hi + last_lo, per(~cur));
      chk(last_hi >= per(~cur) / 2 - 1 && last_hi <= per(~cur) / 2 + 1,
          "R2 follows new source", last_hi, per(~cur) / 2);
      chk(pclk_hi >= per(~cur) - 1 && pclk_hi <= per(~cur) + 1,
          "R3 pclk after switch", pclk_hi, per(~cur));
      cur = ~cur;
    end

    chk(runt_err == 0, "R8 no runt pulse", runt_err, 0);
    chk(pclk_err == 0, "R3 pclk only on clk fall", pclk_err, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule